// File: doc/BRIEF.md
# I2C Frame Bit Counter with Transmit Interrupt Requests

This block counts the bits of one I2C data frame against the rising edges of SCL. It also produces the two transmit-side interrupt requests. Software writes a 3-bit length code into an 8-bit control register. The frame always ends with one acknowledge bit, and the code counts that bit. Code 000 selects the longest frame of nine bits. Codes 001 to 111 select frames of two to eight bits. While a frame runs, the same field reads back how many bits are still to come. After the acknowledge bit the field clears to 000 by itself, so the next frame is nine bits long unless software loads another code.

The control register also holds the transmit-data-empty enable in bit 7 and the transmit-end enable in bit 6. When a frame completes with the transmit buffer empty, the block sets a transmit-end flag. Each request is gated by its own enable. A one-cycle frame-done strobe tells the shift register and the flag logic that the acknowledge bit has been counted.

The counter is a two-state machine. `ST_ARMED` waits between frames. Transition T1 (ARMED to COUNT) fires on the first SCL rising edge after a load or after the previous frame, and it counts that edge as the first bit. `ST_COUNT` decrements the remaining count on each SCL rising edge. Transition T2 (COUNT to ARMED) fires on the edge that counts the last bit. That edge raises frame completion and clears the code.

Top module: `i2c_frame_bitcnt`

## Requirements
- R1: The code sets the frame length, acknowledge included: 000 gives 9 bits, and a code n from 1 to 7 gives n+1 bits. Exactly that many SCL rising edges complete a frame.
- R2: The first SCL rising edge in the armed state starts a frame and counts as one bit. Each later rising edge in the frame counts exactly one more bit.
- R3: Control register bits [2:0] read back the remaining bits minus one, modulo 8, while a frame runs. In the armed state they read the stored code.
- R4: When a frame completes, the code field returns to 000.
- R5: `frame_done_o` is high for exactly one clock, in the cycle after the clock edge that sampled the SCL rising edge of the last bit.
- R6: A non-zero code write is ignored while `scl_high_i` is 1 or while a frame runs. A code write of 000 is accepted whenever the counter is armed, whatever the SCL level.
- R7: `txi_req_o` equals `tdre_i` AND the transmit enable, which is control bit 7.
- R8: `tend_o` is set by a frame-completing SCL edge while `tdre_i` is 1. It stays set until a `tend_clr_i` pulse clears it. A set and a clear in the same cycle leave it set.
- R9: `tei_req_o` equals `tend_o` AND the transmit-end enable, which is control bit 6. Clearing either one removes the request.
- R10: After reset, both enables are 0, the code is 000, the counter is armed, and `tend_o`, `frame_done_o` and both requests are low.
- R11: Control bits [5:3] always read 0. Bits 7 and 6 take the written value on every write, whatever the SCL level or counter state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_rise_i | input | 1 | One-clock strobe marking an SCL rising edge |
| scl_high_i | input | 1 | Current SCL level, 1 while high |
| tdre_i | input | 1 | Transmit data register empty flag |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 8 | Control register write data |
| ctl_rdata_o | output | 8 | Control register read data (enables and remaining-count field) |
| tend_clr_i | input | 1 | Software clear of the transmit-end flag |
| tend_o | output | 1 | Transmit-end flag |
| frame_done_o | output | 1 | One-clock frame completion strobe |
| txi_req_o | output | 1 | Transmit-data-empty interrupt request |
| tei_req_o | output | 1 | Transmit-end interrupt request |

## Verification
A wrong remaining count shows up in the read-back field on the very next clock after the SCL edge that caused it. It also moves `frame_done_o` and `tend_o` earlier or later by whole SCL periods. A state machine stuck in COUNT shows at the ports as a missing frame-done pulse, and the code field then never returns to 000. The bench carries a behavioural model and compares every output on every clock, so any such divergence is flagged in the cycle where it first appears.

// File: rtl/i2c_frame_bitcnt_pkg.sv
package i2c_frame_bitcnt_pkg;

    typedef enum logic [0:0] {
        ST_ARMED = 1'b0,
        ST_COUNT = 1'b1
    } bitcnt_state_e;

endpackage

// File: rtl/i2c_frame_bitcnt_seq.sv
module i2c_frame_bitcnt_seq
    import i2c_frame_bitcnt_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic [CODE_W-1:0] code,
    output logic              armed,
    output logic              frame_end,
    output logic              done_q,
    output logic [CODE_W-1:0] left_code
);

    localparam int REM_W = CODE_W + 1;
    localparam logic [REM_W-1:0] MAX_LEN = REM_W'((1 << CODE_W) + 1);

    bitcnt_state_e    state_q, state_d;
    logic [REM_W-1:0] rem_q, rem_d;
    logic [REM_W-1:0] frame_len;

    assign frame_len = (code == '0) ? MAX_LEN : (REM_W'(code) + REM_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
        end
    end

    // transitions T1 (ARMED->COUNT) and T2 (COUNT->ARMED)
    always_comb begin
        state_d   = state_q;
        rem_d     = rem_q;
        frame_end = 1'b0;
        unique case (state_q)
            ST_ARMED: begin
                if (scl_rise) begin
                    state_d = ST_COUNT;
                    rem_d   = frame_len - REM_W'(1);
                end
            end
            ST_COUNT: begin
                if (scl_rise) begin
                    if (rem_q == REM_W'(1)) begin
                        state_d   = ST_ARMED;
                        rem_d     = '0;
                        frame_end = 1'b1;
                    end else begin
                        rem_d = rem_q - REM_W'(1);
                    end
                end
            end
            default: begin
                state_d = ST_ARMED;
                rem_d   = '0;
            end
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= frame_end;
        end
    end

    assign armed     = (state_q == ST_ARMED);
    assign left_code = armed ? code : CODE_W'(rem_q - REM_W'(1));

endmodule

// File: rtl/i2c_frame_bitcnt_ctl.sv
module i2c_frame_bitcnt_ctl #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              wr_tx_en,
    input  logic              wr_te_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              scl_high,
    input  logic              armed,
    input  logic              frame_end,
    output logic              tx_en,
    output logic              te_en,
    output logic [CODE_W-1:0] code
);

    logic code_ok;

    assign code_ok = we && armed && ((wr_code == '0) || !scl_high);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en <= 1'b0;
            te_en <= 1'b0;
            code  <= '0;
        end else begin
            if (we) begin
                tx_en <= wr_tx_en;
                te_en <= wr_te_en;
            end
            if (frame_end) begin
                code <= '0;
            end else if (code_ok) begin
                code <= wr_code;
            end
        end
    end

endmodule

// File: rtl/i2c_frame_bitcnt_irq.sv
module i2c_frame_bitcnt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_end,
    input  logic tdre,
    input  logic tend_clr,
    input  logic tx_en,
    input  logic te_en,
    output logic tend,
    output logic txi_req,
    output logic tei_req
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tend <= 1'b0;
        end else if (frame_end && tdre) begin
            tend <= 1'b1;
        end else if (tend_clr) begin
            tend <= 1'b0;
        end
    end

    assign txi_req = tdre && tx_en;
    assign tei_req = tend && te_en;

endmodule

// File: rtl/i2c_frame_bitcnt.sv
module i2c_frame_bitcnt #(
    parameter int REG_W  = 8,
    parameter int CODE_W = 3,
    parameter int TX_BIT = 7,
    parameter int TE_BIT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise_i,
    input  logic             scl_high_i,
    input  logic             tdre_i,
    input  logic             ctl_we_i,
    input  logic [REG_W-1:0] ctl_wdata_i,
    output logic [REG_W-1:0] ctl_rdata_o,
    input  logic             tend_clr_i,
    output logic             tend_o,
    output logic             frame_done_o,
    output logic             txi_req_o,
    output logic             tei_req_o
);

    logic              armed, frame_end, tx_en, te_en;
    logic [CODE_W-1:0] code, left_code;
    logic              wdata_unused;

    assign wdata_unused = ^ctl_wdata_i;

    i2c_frame_bitcnt_seq #(.CODE_W(CODE_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise_i),
        .code      (code),
        .armed     (armed),
        .frame_end (frame_end),
        .done_q    (frame_done_o),
        .left_code (left_code)
    );

    i2c_frame_bitcnt_ctl #(.CODE_W(CODE_W)) ctl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (ctl_we_i),
        .wr_tx_en  (ctl_wdata_i[TX_BIT]),
        .wr_te_en  (ctl_wdata_i[TE_BIT]),
        .wr_code   (ctl_wdata_i[CODE_W-1:0]),
        .scl_high  (scl_high_i),
        .armed     (armed),
        .frame_end (frame_end),
        .tx_en     (tx_en),
        .te_en     (te_en),
        .code      (code)
    );

    i2c_frame_bitcnt_irq irq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .tdre      (tdre_i),
        .tend_clr  (tend_clr_i),
        .tx_en     (tx_en),
        .te_en     (te_en),
        .tend      (tend_o),
        .txi_req   (txi_req_o),
        .tei_req   (tei_req_o)
    );

    always_comb begin
        ctl_rdata_o              = '0;
        ctl_rdata_o[TX_BIT]      = tx_en;
        ctl_rdata_o[TE_BIT]      = te_en;
        ctl_rdata_o[CODE_W-1:0]  = left_code;
    end

endmodule

// File: rtl/i2c_frame_bitcnt_chk.sv
module i2c_frame_bitcnt_chk #(
    parameter int REG_W  = 8,
    parameter int CODE_W = 3,
    parameter int TX_BIT = 7,
    parameter int TE_BIT = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_rise_i,
    input logic             scl_high_i,
    input logic             tdre_i,
    input logic             ctl_we_i,
    input logic [REG_W-1:0] ctl_wdata_i,
    input logic [REG_W-1:0] ctl_rdata_o,
    input logic             tend_o,
    input logic             frame_done_o,
    input logic             txi_req_o,
    input logic             tei_req_o
);

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> !frame_done_o);

    a_r4_code_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> (ctl_rdata_o[CODE_W-1:0] == '0));

    a_r7_txi_gate: assert property (@(posedge clk) disable iff (!rst_n)
        txi_req_o == (tdre_i && ctl_rdata_o[TX_BIT]));

    a_r9_tei_gate: assert property (@(posedge clk) disable iff (!rst_n)
        tei_req_o == (tend_o && ctl_rdata_o[TE_BIT]));

    a_r8_tend_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tend_o) |-> $past(tdre_i && scl_rise_i));

    a_r6_high_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we_i && scl_high_i && !scl_rise_i && (ctl_wdata_i[CODE_W-1:0] != '0))
        |=> $stable(ctl_rdata_o[CODE_W-1:0]));

    a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata_o[TE_BIT-1:CODE_W] == '0);

endmodule

bind i2c_frame_bitcnt i2c_frame_bitcnt_chk #(
    .REG_W (REG_W),
    .CODE_W(CODE_W),
    .TX_BIT(TX_BIT),
    .TE_BIT(TE_BIT)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_rise_i   (scl_rise_i),
    .scl_high_i   (scl_high_i),
    .tdre_i       (tdre_i),
    .ctl_we_i     (ctl_we_i),
    .ctl_wdata_i  (ctl_wdata_i),
    .ctl_rdata_o  (ctl_rdata_o),
    .tend_o       (tend_o),
    .frame_done_o (frame_done_o),
    .txi_req_o    (txi_req_o),
    .tei_req_o    (tei_req_o)
);

// File: tb/i2c_frame_bitcnt_tb.sv
`timescale 1ns/1ps
module i2c_frame_bitcnt_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_rise = 1'b0, scl_high = 1'b0, tdre = 1'b0;
    logic       ctl_we = 1'b0, tend_clr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic [7:0] ctl_rdata;
    logic       tend, frame_done, txi_req, tei_req;

    int checks = 0;
    int errors = 0;
    int done_total = 0;
    bit cmp_en = 1'b0;

    always #5 clk = ~clk;

    i2c_frame_bitcnt dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_rise_i   (scl_rise),
        .scl_high_i   (scl_high),
        .tdre_i       (tdre),
        .ctl_we_i     (ctl_we),
        .ctl_wdata_i  (ctl_wdata),
        .ctl_rdata_o  (ctl_rdata),
        .tend_clr_i   (tend_clr),
        .tend_o       (tend),
        .frame_done_o (frame_done),
        .txi_req_o    (txi_req),
        .tei_req_o    (tei_req)
    );

    // behavioural reference model
    int m_code, m_rem, m_run, m_tend, m_txie, m_teie, m_done;
    int n_code, n_rem, n_run, n_tend, n_txie, n_teie, n_done, fe;

    function automatic int flen(int c);
        return (c == 0) ? 9 : c + 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_code = 0; m_rem = 0; m_run = 0; m_tend = 0;
            m_txie = 0; m_teie = 0; m_done = 0;
        end else begin
            n_code = m_code; n_rem = m_rem; n_run = m_run; n_tend = m_tend;
            n_txie = m_txie; n_teie = m_teie;
            fe = (m_run == 1 && scl_rise && m_rem == 1) ? 1 : 0;
            if (scl_rise) begin
                if (m_run == 0) begin
                    n_run = 1; n_rem = flen(m_code) - 1;
                end else if (m_rem == 1) begin
                    n_run = 0; n_rem = 0; n_code = 0;
                end else begin
                    n_rem = m_rem - 1;
                end
            end
            if (ctl_we) begin
                n_txie = ctl_wdata[7];
                n_teie = ctl_wdata[6];
                if (m_run == 0 && fe == 0 && (ctl_wdata[2:0] == 0 || !scl_high))
                    n_code = ctl_wdata[2:0];
            end
            if (fe == 1 && tdre) n_tend = 1;
            else if (tend_clr) n_tend = 0;
            n_done = fe;
            m_code = n_code; m_rem = n_rem; m_run = n_run; m_tend = n_tend;
            m_txie = n_txie; m_teie = n_teie; m_done = n_done;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (frame_done) done_total++;
        if (rst_n && cmp_en) begin
            int efield;
            efield = (m_run == 1) ? ((m_rem - 1) & 7) : m_code;
            chk(int'(ctl_rdata[2:0]) == efield, "R3 count field", ctl_rdata[2:0], efield);
            chk(ctl_rdata[7] == m_txie[0] && ctl_rdata[6] == m_teie[0], "R11 enable bits",
                ctl_rdata[7:6], {m_txie[0], m_teie[0]});
            chk(ctl_rdata[5:3] == 3'b000, "R11 reserved bits", ctl_rdata[5:3], 0);
            chk(int'(frame_done) == m_done, "R5 frame done", frame_done, m_done);
            chk(int'(tend) == m_tend, "R8 tend flag", tend, m_tend);
            chk(txi_req == (tdre & m_txie[0]), "R7 txi request", txi_req, tdre & m_txie[0]);
            chk(tei_req == (m_tend[0] & m_teie[0]), "R9 tei request", tei_req,
                m_tend[0] & m_teie[0]);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk) #1;
    endtask

    task automatic wr(input logic [7:0] d);
        @(posedge clk) #1; ctl_we = 1'b1; ctl_wdata = d;
        @(posedge clk) #1; ctl_we = 1'b0;
    endtask

    task automatic scl_edge();
        @(posedge clk) #1; scl_rise = 1'b1; scl_high = 1'b1;
        @(posedge clk) #1; scl_rise = 1'b0;
        @(posedge clk) #1; scl_high = 1'b0;
    endtask

    task automatic clr_tend();
        @(posedge clk) #1; tend_clr = 1'b1;
        @(posedge clk) #1; tend_clr = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int d0;
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(ctl_rdata == 8'h00, "R10 reset rdata", ctl_rdata, 0);
        chk(!tend && !frame_done && !txi_req && !tei_req, "R10 reset outputs",
            {tend, frame_done, txi_req, tei_req}, 0);
        cmp_en = 1'b1;

        // R1 R2 R4: every code, tdre alternating
        for (int c = 0; c < 8; c++) begin
            int len;
            len = flen(c);
            tdre = c[0];
            wr({2'b11, 3'b000, 3'(c)});
            @(negedge clk);
            chk(int'(ctl_rdata[2:0]) == c, "R3 armed readback", ctl_rdata[2:0], c);
            d0 = done_total;
            for (int e = 0; e < len - 1; e++) scl_edge();
            @(negedge clk);
            chk(done_total == d0, "R1 no early completion", done_total - d0, 0);
            chk(int'(ctl_rdata[2:0]) == 0, "R2 one bit left reads 0", ctl_rdata[2:0], 0);
            scl_edge();
            @(negedge clk);
            chk(done_total == d0 + 1, "R1 frame length", done_total - d0, 1);
            chk(ctl_rdata[2:0] == 3'b000, "R4 code returns to 000", ctl_rdata[2:0], 0);
            chk(tend == tdre, "R8 tend follows tdre at end", tend, tdre);
            clr_tend();
            @(negedge clk);
            chk(!tend, "R8 tend cleared", tend, 0);
        end

        // R6: non-zero write with SCL high is ignored
        scl_high = 1'b1;
        wr(8'h03);
        @(negedge clk);
        chk(ctl_rdata[2:0] == 3'b000, "R6 write while high ignored", ctl_rdata[2:0], 0);
        scl_high = 1'b0;
        wr(8'h03);
        @(negedge clk);
        chk(ctl_rdata[2:0] == 3'b011, "R6 write while low accepted", ctl_rdata[2:0], 3);
        // R6: zero write accepted with SCL high
        scl_high = 1'b1;
        wr(8'h00);
        @(negedge clk);
        chk(ctl_rdata[2:0] == 3'b000, "R6 zero write while high", ctl_rdata[2:0], 0);
        scl_high = 1'b0;
        // R6: write during a frame is ignored
        wr(8'h03);
        scl_edge();
        wr(8'h05);
        @(negedge clk);
        chk(ctl_rdata[2:0] == 3'b010, "R6 write in frame ignored", ctl_rdata[2:0], 2);
        scl_edge();
        scl_edge();
        scl_edge();
        @(negedge clk);
        chk(ctl_rdata[2:0] == 3'b000, "R4 cleared after 4-bit frame", ctl_rdata[2:0], 0);

        // R8: set and clear in the same cycle leaves tend set
        tdre = 1'b1;
        wr(8'hC1);
        scl_edge();
        @(posedge clk) #1; scl_rise = 1'b1; scl_high = 1'b1; tend_clr = 1'b1;
        @(posedge clk) #1; scl_rise = 1'b0; tend_clr = 1'b0;
        @(negedge clk);
        chk(tend, "R8 set wins over clear", tend, 1);
        scl_high = 1'b0;
        // R9: dropping the enable removes the request
        chk(tei_req, "R9 request with enable", tei_req, 1);
        wr(8'h80);
        @(negedge clk);
        chk(!tei_req && tend, "R9 enable cleared", tei_req, 0);
        // R7: txi follows enable and tdre
        chk(txi_req, "R7 txi with tdre", txi_req, 1);
        tdre = 1'b0;
        @(negedge clk);
        chk(!txi_req, "R7 txi without tdre", txi_req, 0);
        // R11: enables written while SCL high, code kept
        scl_high = 1'b1;
        wr(8'hFF);
        @(negedge clk);
        chk(ctl_rdata == 8'hC0, "R11 enables write in any state", ctl_rdata, 8'hC0);
        scl_high = 1'b0;
        cyc(4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule